// File: doc/BRIEF.md
# Level-Sensitive Interrupt Router with Claim/Complete

The block collects level requests from `NSRC` external sources and routes them to `NTGT` targets. Every source has its own priority register. Every target has an enable bitmap, a threshold register and a claim/complete register, and it drives one request line. All of these registers sit behind a word-addressed bus with a single port. Source ID 0 is reserved to mean "nothing". Real sources are numbered 1 to `NSRC`, and source `s` enters on input bit `s-1`.

A target reads its claim register to take the best candidate. That read clears the pending bit of the returned source in the same cycle and holds the source in flight. While a source is in flight, its level cannot make it pending again. The target then writes a source ID back to the same address. If that ID is enabled for the writing target, the source leaves flight and its level is sampled again. If it is not enabled, the write does nothing. The completion ID is never compared with what the target last claimed.

Word address map (default `ADDR_W` = 10). Priorities sit at `0x000 + s`. Enables sit at `0x100 + 8*t + w`. Thresholds sit at `0x200 + 2*t`. The claim/complete register sits at `0x201 + 2*t`. Bus reads are combinational. Writes and claim side effects take place at the clock edge.

Top module: `irq_router`

## Requirements
- R1: After reset every priority, threshold, enable bit, pending bit and in-flight bit is zero. All `irq_o` lines are low and every claim read returns 0.
- R2: A claim read for target t returns the ID of the pending source enabled for t that has the largest priority. Equal priorities go to the smaller ID. A source with priority 0 never wins. The read returns 0 if no source qualifies.
- R3: A claim that returns source s clears s's pending bit at that edge. s cannot become pending again until it has been completed, even if its level stays high.
- R4: The claim result does not depend on the target's threshold.
- R5: `irq_o[t]` is high exactly when some pending source enabled for t has a priority strictly greater than t's threshold.
- R6: A write of ID d to target t's claim/complete address releases d from flight whenever d is in 1..NSRC and enabled for t. This holds whatever t last claimed.
- R7: A completion whose ID is not enabled for the writing target is ignored. The source stays in flight and cannot be claimed.
- R8: Enable bits are packed 32 per word: source s is bit s&31 of word s>>5 in the target's block. Bit 0 of word 0 and bits above `NSRC` read as 0. Priority reads return the value written, truncated to `PRIO_W` bits.
- R9: After a valid completion, a source whose level is still high becomes pending again one edge later. From then on it can be claimed.
- R10: A pending bit stays set after the source's level falls, until it is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Level requests; bit s-1 is source s |
| bus_re | input | 1 | Read strobe (claim side effect on claim addresses) |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_o | output | NTGT | Interrupt request per target |

## Verification
A claim can fall in the same cycle as pending capture for the source it returns. The bench claims a source while holding its level high, then claims again at once: the second claim must return 0 and not the same ID. Completion also meets capture when a completion is written while the level is still high. The claim read in the cycle right after the completion must still return 0, and the one after that must return the ID. Random traffic mixes both cases with register writes, and a bench model that follows the requirements judges every read and every cycle's `irq_o`.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC   = 40,
  parameter int NTGT   = 2,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_re,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NTGT-1:0]   irq_o
);
  localparam int SID_W = $clog2(NSRC + 1);
  localparam int TW    = (NTGT > 1) ? $clog2(NTGT) : 1;

  logic [PRIO_W-1:0] prio [1:NSRC];
  logic [NSRC:1]     en   [NTGT];
  logic [PRIO_W-1:0] thr  [NTGT];
  logic [NSRC:1]     pend, infl, claim_vec, cmpl_vec;
  logic [SID_W-1:0]  best_id [NTGT];
  logic [PRIO_W-1:0] best_p  [NTGT];

  logic [1:0] region;
  logic [7:0] idx;
  logic [6:0] ctl_t;
  logic [TW-1:0] cl_t;
  logic tgt_ok, is_claim;

  assign region   = bus_addr[ADDR_W-1 -: 2];
  assign idx      = bus_addr[7:0];
  assign ctl_t    = idx[7:1];
  assign cl_t     = ctl_t[TW-1:0];
  assign tgt_ok   = int'(ctl_t) < NTGT;
  assign is_claim = (region == 2'd2) && idx[0] && tgt_ok;

  always_comb begin
    for (int t = 0; t < NTGT; t++) begin
      best_id[t] = '0;
      best_p[t]  = '0;
      for (int s = 1; s <= NSRC; s++)
        if (pend[s] && en[t][s] && prio[s] > best_p[t]) begin
          best_p[t]  = prio[s];
          best_id[t] = SID_W'(s);
        end
    end
  end

  genvar gs, gt;
  generate
    for (gt = 0; gt < NTGT; gt++) begin : g_tgt
      assign irq_o[gt] = best_p[gt] > thr[gt];

      assert_irq_has_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o[gt] |-> best_id[gt] != '0);

      for (gs = 1; gs <= NSRC; gs++) begin : g_ign
        assert_ignored_cmpl_R7: assert property (@(posedge clk) disable iff (!rst_n)
          (bus_we && is_claim && int'(cl_t) == gt && bus_wdata == 32'(gs)
           && !en[gt][gs] && infl[gs]) |=> infl[gs]);
      end
    end

    for (gs = 1; gs <= NSRC; gs++) begin : g_src
      assign claim_vec[gs] = bus_re && is_claim && best_id[cl_t] == SID_W'(gs);
      assign cmpl_vec[gs]  = bus_we && is_claim && bus_wdata == 32'(gs) && en[cl_t][gs];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend[gs] <= 1'b0;
          infl[gs] <= 1'b0;
        end else if (claim_vec[gs]) begin
          pend[gs] <= 1'b0;
          infl[gs] <= 1'b1;
        end else if (cmpl_vec[gs]) begin
          infl[gs] <= 1'b0;
        end else if (src_i[gs-1] && !infl[gs]) begin
          pend[gs] <= 1'b1;
        end
      end

      assert_claim_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        claim_vec[gs] |=> !pend[gs] && infl[gs]);
      assert_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        infl[gs] |-> !pend[gs]);
      assert_claimed_was_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(infl[gs]) |-> $past(pend[gs]));
      assert_pend_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend[gs] && !claim_vec[gs]) |=> pend[gs]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 1; s <= NSRC; s++) prio[s] <= '0;
      for (int t = 0; t < NTGT; t++) begin
        en[t]  <= '0;
        thr[t] <= '0;
      end
    end else if (bus_we) begin
      for (int s = 1; s <= NSRC; s++)
        if (region == 2'd0 && int'(idx) == s) prio[s] <= bus_wdata[PRIO_W-1:0];
      for (int t = 0; t < NTGT; t++) begin
        for (int s = 1; s <= NSRC; s++)
          if (region == 2'd1 && int'(idx[7:3]) == t && int'(idx[2:0]) == s / 32)
            en[t][s] <= bus_wdata[s % 32];
        if (region == 2'd2 && !idx[0] && int'(ctl_t) == t)
          thr[t] <= bus_wdata[PRIO_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (region)
      2'd0: for (int s = 1; s <= NSRC; s++)
              if (int'(idx) == s) bus_rdata = 32'(prio[s]);
      2'd1: for (int t = 0; t < NTGT; t++)
              for (int s = 1; s <= NSRC; s++)
                if (int'(idx[7:3]) == t && int'(idx[2:0]) == s / 32)
                  bus_rdata[s % 32] = en[t][s];
      2'd2: for (int t = 0; t < NTGT; t++)
              if (int'(ctl_t) == t)
                bus_rdata = idx[0] ? 32'(best_id[t]) : 32'(thr[t]);
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: tb/irq_router_tb.sv
`timescale 1ns/1ps
module irq_router_tb;
  localparam int NS = 40;
  localparam int NT = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] lv = '0;
  logic re = 1'b0, we = 1'b0;
  logic [9:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NT-1:0] irq;

  irq_router #(.NSRC(NS), .NTGT(NT), .PRIO_W(3), .ADDR_W(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(lv), .bus_re(re), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq));

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  int m_prio [1:NS];
  bit m_en [NT][1:NS];
  int m_thr [NT];
  bit m_pend [1:NS];
  bit m_infl [1:NS];

  function automatic int m_claim(int t);
    int best = 0, bp = 0;
    for (int s = 1; s <= NS; s++)
      if (m_pend[s] && m_en[t][s] && m_prio[s] > bp) begin bp = m_prio[s]; best = s; end
    return best;
  endfunction

  function automatic bit m_irq(int t);
    int bp = 0;
    for (int s = 1; s <= NS; s++)
      if (m_pend[s] && m_en[t][s] && m_prio[s] > bp) bp = m_prio[s];
    return bp > m_thr[t];
  endfunction

  function automatic logic [31:0] m_enword(int t, int w);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++)
      if (w * 32 + b >= 1 && w * 32 + b <= NS) v[b] = m_en[t][w * 32 + b];
    return v;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_edge(bit r, bit w, logic [9:0] a, logic [31:0] d, logic [NS-1:0] l);
    int t = int'(a[7:1]);
    int cid = 0, did = 0;
    if (r && a[9:8] == 2'd2 && a[0] && t < NT) cid = m_claim(t);
    if (w && a[9:8] == 2'd2 && a[0] && t < NT && d >= 1 && d <= NS)
      if (m_en[t][int'(d)]) did = int'(d);
    for (int s = 1; s <= NS; s++) begin
      if (s == cid) begin m_pend[s] = 0; m_infl[s] = 1; end
      else if (s == did) m_infl[s] = 0;
      else if (l[s-1] && !m_infl[s]) m_pend[s] = 1;
    end
    if (w) begin
      if (a[9:8] == 2'd0 && a[7:0] >= 1 && a[7:0] <= NS) m_prio[int'(a[7:0])] = int'(d[2:0]);
      if (a[9:8] == 2'd1 && int'(a[7:3]) < NT)
        for (int b = 0; b < 32; b++)
          if (int'(a[2:0]) * 32 + b >= 1 && int'(a[2:0]) * 32 + b <= NS)
            m_en[int'(a[7:3])][int'(a[2:0]) * 32 + b] = d[b];
      if (a[9:8] == 2'd2 && !a[0] && t < NT) m_thr[t] = int'(d[2:0]);
    end
  endtask

  // one bus cycle starting and ending at a falling edge; rd is sampled before the edge
  task automatic step(bit r, bit w, logic [9:0] a, logic [31:0] d, output logic [31:0] rd);
    re = r; we = w; addr = a; wdata = d;
    #1 rd = rdata;
    @(posedge clk);
    model_edge(r, w, a, d, lv);
    @(negedge clk);
    re = 0; we = 0;
    for (int t = 0; t < NT; t++) chk("R5 irq per cycle", 32'(irq[t]), 32'(m_irq(t)));
  endtask

  task automatic idle(); logic [31:0] x; step(0, 0, 10'h0, 0, x); endtask
  task automatic wr(logic [9:0] a, logic [31:0] d); logic [31:0] x; step(0, 1, a, d, x); endtask

  task automatic claim(int t, string tag, int lit);
    logic [31:0] x; int e = m_claim(t);
    step(1, 0, 10'(32'h201 + 2 * t), 0, x);
    chk(tag, x, 32'(e));
    if (lit >= 0) chk({tag, " literal"}, x, 32'(lit));
  endtask

  task automatic cmpl(int t, int id); wr(10'(32'h201 + 2 * t), 32'(id)); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    void'($urandom(32'd20240517));
    for (int s = 1; s <= NS; s++) begin m_prio[s] = 0; m_pend[s] = 0; m_infl[s] = 0; end
    for (int t = 0; t < NT; t++) begin m_thr[t] = 0; for (int s = 1; s <= NS; s++) m_en[t][s] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    lv = '1;
    claim(0, "R1 claim after reset", 0);
    step(1, 0, 10'h005, 0, x); chk("R1 prio", x, 0);
    step(1, 0, 10'h108, 0, x); chk("R1 enable", x, 0);
    lv = '0;
    for (int t = 0; t < NT; t++)
      for (int s = 1; s <= NS; s++) begin m_pend[s] = m_pend[s]; end

    // R8 packing
    wr(10'h100, 32'hFFFF_FFFF);
    wr(10'h101, 32'hFFFF_FFFF);
    step(1, 0, 10'h100, 0, x); chk("R8 word0 bit0 reads 0", x, 32'hFFFF_FFFE);
    step(1, 0, 10'h101, 0, x); chk("R8 word1 above NSRC reads 0", x, 32'h0000_01FF);
    wr(10'h028, 32'h0000_00FD);
    step(1, 0, 10'h028, 0, x); chk("R8 prio truncation", x, 32'h5);
    wr(10'h028, 0);

    // claims were made at reset with all levels high; release whatever is in flight
    for (int s = 1; s <= NS; s++) if (m_infl[s]) cmpl(0, s);
    for (int s = 1; s <= NS; s++) if (m_pend[s]) begin wr(10'(s), 1); claim(0, "R2 drain", -1); wr(10'(s), 0); cmpl(0, s); end

    // R2 tie, zero priority
    wr(10'h003, 2); wr(10'h005, 2); wr(10'h007, 0);
    lv[2] = 1; lv[4] = 1; lv[6] = 1;
    idle();
    chk("R5 irq raised", 32'(irq[0]), 1);
    claim(0, "R2 tie to lower ID", 3);
    claim(0, "R2 second", 5);
    claim(0, "R2 priority zero never wins", 0);
    chk("R5 irq low after claims", 32'(irq[0]), 0);

    // R3 masked while in flight, level still high
    idle();
    claim(0, "R3 masked in flight", 0);
    // R9 reassert after completion
    cmpl(0, 3);
    claim(0, "R9 same cycle as capture", 0);
    claim(0, "R9 re-pended", 3);
    // R6 completion not matched to last claim
    cmpl(0, 5);
    idle();
    claim(0, "R6 mismatched completion releases 5", 5);
    // R7 completion from a target without the enable
    cmpl(1, 3);
    idle();
    claim(0, "R7 ignored completion keeps 3 masked", 0);
    // R4 threshold ignored by claim
    wr(10'h200, 7);
    cmpl(0, 3);
    idle();
    chk("R5 irq below threshold", 32'(irq[0]), 0);
    claim(0, "R4 claim ignores threshold", 3);
    // R10 latch after level drops
    lv = '0;
    cmpl(0, 3); cmpl(0, 5);
    wr(10'h009, 4); wr(10'h200, 3);
    lv[8] = 1; idle(); lv[8] = 0; idle();
    chk("R5 irq prio4 over thr3", 32'(irq[0]), 1);
    wr(10'h200, 4);
    chk("R5 irq prio4 at thr4", 32'(irq[0]), 0);
    claim(0, "R10 pending held", 9);
    cmpl(0, 9);
    // collision: claim while level high, then claim again immediately
    lv[9] = 1; wr(10'h00A, 6); idle();
    claim(0, "R3 collision claim", 10);
    claim(0, "R3 collision no re-pend", 0);
    cmpl(0, 10); lv[9] = 0;

    // random phase
    for (int i = 0; i < 1500; i++) begin
      int op = $urandom_range(0, 9);
      int t = $urandom_range(0, NT - 1);
      int s = $urandom_range(1, NS);
      if ($urandom_range(0, 3) == 0) lv = NS'({$urandom, $urandom}) & NS'({$urandom, $urandom});
      case (op)
        0: wr(10'(s), $urandom);
        1: wr(10'(32'h100 + 8 * t + $urandom_range(0, 1)), $urandom);
        2: wr(10'(32'h200 + 2 * t), $urandom_range(0, 7));
        3, 4, 5: claim(t, "R2 random claim", -1);
        6, 7: cmpl(t, $urandom_range(0, NS + 2));
        8: begin
             int w = $urandom_range(0, 1);
             step(1, 0, 10'(32'h100 + 8 * t + w), 0, x);
             chk("R8 random enable read", x, m_enword(t, w));
           end
        default: begin
             step(1, 0, 10'(s), 0, x);
             chk("R8 random prio read", x, 32'(m_prio[s]));
           end
      endcase
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule